// File: doc/BRIEF.md
# Timer Interrupt Status Controller

This block turns two timer events into interrupt requests for a processor core. The first source is a decrementer: an external counter delivers a one-cycle expiry pulse. The second source is a fixed-interval timer. It watches one software-selected bit of a free-running time base and fires when that bit goes from 0 to 1.

Each source owns a sticky status flag. A flag stays set until software writes a one to its bit of the clear word. While the flag is set and both the source's enable and the global external-interrupt enable are on, a request line stays high. The request therefore repeats until the handler clears the flag.

Requests are held off while the core reports a higher-priority exception. When both sources would request at once, the decrementer wins.

Top module: `tir_ctrl`

## Requirements
- R1: A cycle with `dec_expire_i` high sets status bit 0 (decrementer flag) at the following clock edge.
- R2: `dec_irq_o` is high exactly when status bit 0, `dec_ie_i` and `ext_ie_i` are all 1 and `hi_pri_pend_i` is 0.
- R3: `tap_sel_i` values 0, 1, 2 and 3 select time-base bit `TAP0`, `TAP1`, `TAP2` and `TAP3` (defaults 4, 8, 12, 16). The selected bit being 0 in one cycle and 1 in the next sets status bit 1 (fixed-interval flag) at the end of that next cycle. A falling edge, a steady level, or a change on an unselected bit sets nothing.
- R4: `fit_irq_o` is high when status bit 1, `fit_ie_i` and `ext_ie_i` are all 1, `hi_pri_pend_i` is 0, and `dec_irq_o` is low.
- R5: A set status flag stays set, cycle after cycle, until it is cleared.
- R6: A cycle with `clr_valid_i` high clears each status bit whose `clr_mask_i` bit is 1. Mask bit 0 addresses the decrementer and bit 1 the fixed-interval flag. Bits whose mask bit is 0 are unchanged.
- R7: When a clear and a new event for the same flag fall in the same cycle, the flag ends set.
- R8: The cycle in which `tap_sel_i` differs from its previous value yields no fixed-interval event, and neither does the first cycle after reset, whatever the new tap's level.
- R9: The decrementer request has priority: `dec_irq_o` and `fit_irq_o` are never high together.
- R10: While `hi_pri_pend_i` is 1, both request lines are low.
- R11: During and right after reset, the status word is 0 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_expire_i | input | 1 | Decrementer expiry pulse |
| tb_value_i | input | TB_W | Free-running time-base value |
| tap_sel_i | input | 2 | Fixed-interval tap selection |
| dec_ie_i | input | 1 | Decrementer interrupt enable |
| fit_ie_i | input | 1 | Fixed-interval interrupt enable |
| ext_ie_i | input | 1 | Global external-interrupt enable |
| hi_pri_pend_i | input | 1 | A higher-priority exception is pending |
| clr_valid_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | 2 | Bits to clear (bit 0 decrementer, bit 1 fixed-interval) |
| status_o | output | 2 | Sticky status flags (bit 0 decrementer, bit 1 fixed-interval) |
| dec_irq_o | output | 1 | Decrementer interrupt request |
| fit_irq_o | output | 1 | Fixed-interval interrupt request |

## Verification
The assertions take all inputs as synchronous to `clk` and read the clear mask only in cycles where `clr_valid_i` is high. The clear-effect property only applies when no same-cycle event hits the same flag, so it leaves the set-wins case to its own rule. The stimulus changes inputs one time unit after a rising edge and holds them for the whole cycle. It drives expiry pulses and clear strobes for single cycles and moves the tap selection only while the time base is held still, so each observed edge has one known cause.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int NSRC    = 2;
  localparam int SRC_DEC = 0;
  localparam int SRC_FIT = 1;
  localparam int NTAP    = 4;
  localparam int SEL_W   = $clog2(NTAP);

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/tir_tap_edge.sv
module tir_tap_edge
  import tir_pkg::*;
#(
  parameter int TB_W = 32,
  parameter int TAP0 = 4,
  parameter int TAP1 = 8,
  parameter int TAP2 = 12,
  parameter int TAP3 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o
);
  logic [NTAP-1:0]  taps;
  logic             cur_bit;
  logic             prev_q;
  logic [SEL_W-1:0] sel_q;
  logic             armed_q;
  logic             unused_tb_bits;

  assign taps           = {tb_i[TAP3], tb_i[TAP2], tb_i[TAP1], tb_i[TAP0]};
  assign cur_bit        = taps[sel_i];
  assign unused_tb_bits = ^tb_i;

  // Previous-value register reloads every cycle, so a selection change
  // re-bases it; the event itself is masked in that cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      sel_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= cur_bit;
      sel_q   <= sel_i;
      armed_q <= 1'b1;
    end
  end

  assign rise_o = armed_q && (sel_i == sel_q) && cur_bit && !prev_q;
endmodule

// File: rtl/tir_flag.sv
module tir_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/tir_req_gate.sv
module tir_req_gate
  import tir_pkg::*;
(
  input  src_vec_t flags_i,
  input  src_vec_t ie_i,
  input  logic     ext_ie_i,
  input  logic     hold_i,
  output src_vec_t req_o
);
  src_vec_t eligible;

  assign eligible = flags_i & ie_i & {NSRC{ext_ie_i && !hold_i}};

  // Lower source index has higher priority.
  always_comb begin
    logic taken;
    taken = 1'b0;
    req_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i] && !taken) begin
        req_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tir_ctrl.sv
module tir_ctrl
  import tir_pkg::*;
#(
  parameter int TB_W = 32,
  parameter int TAP0 = 4,
  parameter int TAP1 = 8,
  parameter int TAP2 = 12,
  parameter int TAP3 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_expire_i,
  input  logic [TB_W-1:0]  tb_value_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  input  logic             dec_ie_i,
  input  logic             fit_ie_i,
  input  logic             ext_ie_i,
  input  logic             hi_pri_pend_i,
  input  logic             clr_valid_i,
  input  logic [NSRC-1:0]  clr_mask_i,
  output logic [NSRC-1:0]  status_o,
  output logic             dec_irq_o,
  output logic             fit_irq_o
);
  logic     fit_rise;
  src_vec_t ev_set;
  src_vec_t ev_clr;
  src_vec_t flags;
  src_vec_t ie_vec;
  src_vec_t req;

  tir_tap_edge #(
    .TB_W(TB_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
  ) u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .tb_i  (tb_value_i),
    .sel_i (tap_sel_i),
    .rise_o(fit_rise)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[SRC_DEC] = dec_expire_i;
    ev_set[SRC_FIT] = fit_rise;
    ie_vec          = '0;
    ie_vec[SRC_DEC] = dec_ie_i;
    ie_vec[SRC_FIT] = fit_ie_i;
  end

  assign ev_clr = clr_mask_i & {NSRC{clr_valid_i}};

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    tir_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_set[g]),
      .clr_i (ev_clr[g]),
      .flag_o(flags[g])
    );
  end

  tir_req_gate u_gate (
    .flags_i (flags),
    .ie_i    (ie_vec),
    .ext_ie_i(ext_ie_i),
    .hold_i  (hi_pri_pend_i),
    .req_o   (req)
  );

  assign status_o  = flags;
  assign dec_irq_o = req[SRC_DEC];
  assign fit_irq_o = req[SRC_FIT];
endmodule

// File: rtl/tir_ctrl_chk.sv
module tir_ctrl_chk
  import tir_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            dec_expire_i,
  input logic            ext_ie_i,
  input logic            hi_pri_pend_i,
  input logic            clr_valid_i,
  input logic [NSRC-1:0] clr_mask_i,
  input logic [NSRC-1:0] status_o,
  input logic            dec_irq_o,
  input logic            fit_irq_o
);
  AST_DEC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_expire_i |=> status_o[0]); // R1
  AST_DEC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq_o |-> (status_o[0] && ext_ie_i)); // R2
  AST_FIT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fit_irq_o |-> (status_o[1] && ext_ie_i)); // R4
  AST_DEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[0] && !(clr_valid_i && clr_mask_i[0])) |=> status_o[0]); // R5
  AST_FIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] && !(clr_valid_i && clr_mask_i[1])) |=> status_o[1]); // R5
  AST_DEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && clr_mask_i[0] && !dec_expire_i) |=> !status_o[0]); // R6
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_irq_o, fit_irq_o})); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pri_pend_i |-> (!dec_irq_o && !fit_irq_o)); // R10
endmodule

bind tir_ctrl tir_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dec_expire_i (dec_expire_i),
  .ext_ie_i     (ext_ie_i),
  .hi_pri_pend_i(hi_pri_pend_i),
  .clr_valid_i  (clr_valid_i),
  .clr_mask_i   (clr_mask_i),
  .status_o     (status_o),
  .dec_irq_o    (dec_irq_o),
  .fit_irq_o    (fit_irq_o)
);

// File: tb/tir_ctrl_bench.sv
`timescale 1ns/1ps
module tir_ctrl_bench;
  localparam int TB_W = 32;
  localparam int TAPS [4] = '{4, 8, 12, 16};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            dec_expire_i = 1'b0;
  logic [TB_W-1:0] tb_value_i = '0;
  logic [1:0]      tap_sel_i = '0;
  logic            dec_ie_i = 1'b0;
  logic            fit_ie_i = 1'b0;
  logic            ext_ie_i = 1'b0;
  logic            hi_pri_pend_i = 1'b0;
  logic            clr_valid_i = 1'b0;
  logic [1:0]      clr_mask_i = '0;
  logic [1:0]      status_o;
  logic            dec_irq_o;
  logic            fit_irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tir_ctrl #(.TB_W(TB_W)) u_tir_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_expire_i(dec_expire_i),
    .tb_value_i(tb_value_i), .tap_sel_i(tap_sel_i), .dec_ie_i(dec_ie_i),
    .fit_ie_i(fit_ie_i), .ext_ie_i(ext_ie_i), .hi_pri_pend_i(hi_pri_pend_i),
    .clr_valid_i(clr_valid_i), .clr_mask_i(clr_mask_i), .status_o(status_o),
    .dec_irq_o(dec_irq_o), .fit_irq_o(fit_irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    clr_valid_i = 1'b1; clr_mask_i = 2'b11;
    cyc();
    clr_valid_i = 1'b0; clr_mask_i = 2'b00;
  endtask

  task automatic t_reset();
    tb_value_i = '1;
    rst_n = 1'b0;
    dec_ie_i = 1'b1; fit_ie_i = 1'b1; ext_ie_i = 1'b1;
    repeat (3) cyc();
    check("R11 status in reset", status_o, 0);
    check("R11 dec_irq in reset", dec_irq_o, 0);
    rst_n = 1'b1;
    cyc();
    cyc();
    check("R8 no event after reset with tap high", status_o, 0);
    check("R11 fit_irq after reset", fit_irq_o, 0);
    tb_value_i = '0; dec_ie_i = 0; fit_ie_i = 0; ext_ie_i = 0;
    cyc();
  endtask

  task automatic t_dec();
    dec_expire_i = 1'b1;
    cyc();
    dec_expire_i = 1'b0;
    check("R1 dec flag set", status_o, 1);
    check("R2 dec_irq off while disabled", dec_irq_o, 0);
    dec_ie_i = 1'b1; #1;
    check("R2 dec_irq off without ext_ie", dec_irq_o, 0);
    ext_ie_i = 1'b1; #1;
    check("R2 dec_irq on", dec_irq_o, 1);
    repeat (3) cyc();
    check("R5 dec flag sticky", status_o, 1);
    check("R5 dec_irq repeats", dec_irq_o, 1);
    hi_pri_pend_i = 1'b1; #1;
    check("R10 dec_irq held off", dec_irq_o, 0);
    hi_pri_pend_i = 1'b0;
    clr_valid_i = 1'b1; clr_mask_i = 2'b10;
    cyc();
    check("R6 mask bit 1 leaves dec flag", status_o, 1);
    clr_mask_i = 2'b01;
    cyc();
    clr_valid_i = 1'b0; clr_mask_i = 2'b00;
    check("R6 dec flag cleared", status_o, 0);
    check("R2 dec_irq drops after clear", dec_irq_o, 0);
    dec_ie_i = 0; ext_ie_i = 0;
  endtask

  task automatic t_fit_taps();
    for (int s = 0; s < 4; s++) begin
      tb_value_i = '0;
      tap_sel_i = 2'(s);
      cyc(); cyc();
      tb_value_i = ~(TB_W'(1) << TAPS[s]);
      cyc();
      check($sformatf("R3 unselected bits tap %0d", s), status_o, 0);
      tb_value_i = TB_W'(1) << TAPS[s];
      cyc();
      check($sformatf("R3 rise sets fit flag tap %0d", s), status_o, 2);
      clear_all();
      tb_value_i = '0;
      cyc();
      check($sformatf("R3 fall sets nothing tap %0d", s), status_o, 0);
    end
  endtask

  task automatic t_sel_change();
    tap_sel_i = 2'd0;
    tb_value_i = TB_W'(1) << TAPS[1];
    cyc(); cyc();
    tap_sel_i = 2'd1;
    cyc(); cyc();
    check("R8 tap change makes no event", status_o, 0);
    tb_value_i = '0;
    cyc();
    tb_value_i = TB_W'(1) << TAPS[1];
    cyc();
    check("R3 new tap rise still detected", status_o, 2);
    clear_all();
    tb_value_i = '0; tap_sel_i = 2'd0;
    cyc(); cyc();
  endtask

  task automatic t_set_wins();
    dec_expire_i = 1'b1; clr_valid_i = 1'b1; clr_mask_i = 2'b01;
    cyc();
    dec_expire_i = 1'b0; clr_valid_i = 1'b0; clr_mask_i = 2'b00;
    check("R7 dec set beats clear", status_o, 1);
    clear_all();
    cyc();
    tb_value_i = TB_W'(1) << TAPS[0];
    clr_valid_i = 1'b1; clr_mask_i = 2'b10;
    cyc();
    clr_valid_i = 1'b0; clr_mask_i = 2'b00;
    check("R7 fit set beats clear", status_o, 2);
    clear_all();
    tb_value_i = '0;
    cyc();
  endtask

  task automatic t_priority();
    dec_expire_i = 1'b1;
    tb_value_i = TB_W'(1) << TAPS[0];
    cyc();
    dec_expire_i = 1'b0;
    check("R1 R3 both flags", status_o, 3);
    dec_ie_i = 1; fit_ie_i = 1; ext_ie_i = 1; #1;
    check("R9 dec wins", dec_irq_o, 1);
    check("R9 fit suppressed", fit_irq_o, 0);
    clr_valid_i = 1'b1; clr_mask_i = 2'b01;
    cyc();
    clr_valid_i = 1'b0; clr_mask_i = 2'b00;
    check("R4 fit_irq after dec cleared", fit_irq_o, 1);
    hi_pri_pend_i = 1'b1; #1;
    check("R10 fit_irq held off", fit_irq_o, 0);
    hi_pri_pend_i = 1'b0; fit_ie_i = 1'b0; #1;
    check("R4 fit_irq needs enable", fit_irq_o, 0);
    clear_all();
    dec_ie_i = 0; ext_ie_i = 0; tb_value_i = '0;
    cyc();
  endtask

  initial begin
    t_reset();
    t_dec();
    t_fit_taps();
    t_sel_change();
    t_set_wins();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule